// File: doc/BRIEF.md
# Quad-Rail Digit Codec with Completion Detector

This block moves data words between plain binary and a delay-insensitive quad-rail form. Every pair of binary bits becomes one digit carried on four wires. The sense is inverted: an idle (clear) digit has all four wires high, and a digit that holds a value pulls exactly one wire low. The block encodes a binary word onto rails and decodes a rail word back to binary. It flags malformed digits. It also offers a bitwise complement of a rail word, which it builds from wire swaps alone.

A completion detector watches the rail word presented to the decoder. It reports two things: when every digit carries a value, and when every digit has returned to clear. A registered two-state machine combines these with hysteresis, in the way a tree of Muller C-elements behaves. It goes high only once all digits are valid. It goes low only once all digits are clear. In any mixed state it keeps its last value. A stage controller can use this output to decide when data has landed and when the stage may be reset.

The word width is a parameter, with two bits per digit. The default is a 32-bit word on 16 digits.

Top module: `quad_rail_codec`

## Requirements
- R1: While `enc_valid_i` is low, every bit of `enc_rails_o` is 1 (the clear pattern), whatever `enc_word_i` holds.
- R2: While `enc_valid_i` is high, digit d takes binary bits [2d+1:2d] as value v. It drives rail bit 4d+v of `enc_rails_o` to 0 and the other three rails of that digit to 1.
- R3: A digit of `dec_rails_i` with exactly one rail low, at position v, decodes to value v in bits [2d+1:2d] of `dec_word_o`. A clear digit or a malformed digit decodes to 0.
- R4: `dec_err_o` is 1 exactly when at least one digit of `dec_rails_i` has two or more rails low.
- R5: `inv_rails_o` is `dec_rails_i` with rails 0 and 3, and rails 1 and 2, exchanged in every digit. A value v therefore becomes 3-v, which is the bitwise NOT of the decoded word, and a clear digit stays clear.
- R6: `all_valid_o` is 1 when every digit has at least one rail low. `all_clear_o` is 1 when every rail is high.
- R7: The detector has two states, EMPTY and FULL. It takes the transition EMPTY to FULL (named FILL) at a clock edge where `all_valid_o` is 1. `done_o` is high from that edge onward.
- R8: The detector takes the transition FULL to EMPTY (named DRAIN) only at a clock edge where `all_clear_o` is 1. `done_o` is low from that edge onward.
- R9: At an edge where the digits are partly valid and partly clear, the detector keeps its state, and `done_o` does not change.
- R10: While `rst_n` is low, the detector is in EMPTY and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the detector state |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_valid_i | input | 1 | Selects the encoded word (1) or the clear pattern (0) |
| enc_word_i | input | W | Binary word to encode |
| enc_rails_o | output | 2*W | Inverted quad-rail form of `enc_word_i` |
| dec_rails_i | input | 2*W | Rail word to decode, swap and watch |
| dec_word_o | output | W | Binary value of `dec_rails_i` |
| dec_err_o | output | 1 | Some digit has more than one rail low |
| inv_rails_o | output | 2*W | Rail-swapped complement of `dec_rails_i` |
| all_valid_o | output | 1 | Every digit holds a value |
| all_clear_o | output | 1 | Every digit is clear |
| done_o | output | 1 | Completion with hysteresis |

## Verification
The properties assume that `dec_rails_i` changes only away from the rising clock edge. They also assume that each digit moves between clear and one code. The exception is the dedicated error case, where a digit is driven with two rails low on purpose.

The bench drives every rail word at the falling edge. It builds rail words only from legal digit codes, apart from one malformed digit that tests the error flag. During the set and clear sequences it changes one digit per clock, so the detector passes through every mixed state it is meant to ignore.

// File: rtl/qr_pkg.sv
package qr_pkg;

    localparam int RAILS_PER_DIGIT = 4;
    localparam int BITS_PER_DIGIT  = 2;

    typedef enum logic {
        DET_EMPTY = 1'b0,
        DET_FULL  = 1'b1
    } det_state_e;

    // Inverted sense: the rail selected by the value is driven low.
    function automatic logic [3:0] digit_code(input logic [1:0] v);
        return ~(4'b0001 << v);
    endfunction

    // True-sense one-hot to value; anything else yields zero.
    function automatic logic [1:0] digit_value(input logic [3:0] t);
        logic [1:0] v;
        case (t)
            4'b0001: v = 2'd0;
            4'b0010: v = 2'd1;
            4'b0100: v = 2'd2;
            4'b1000: v = 2'd3;
            default: v = 2'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/qr_encoder.sv
module qr_encoder
    import qr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           valid_i,
    input  logic [W-1:0]   word_i,
    output logic [2*W-1:0] rails_o
);
    localparam int DIGITS = W / BITS_PER_DIGIT;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        assign rails_o[RAILS_PER_DIGIT*g +: RAILS_PER_DIGIT] =
            valid_i ? digit_code(word_i[BITS_PER_DIGIT*g +: BITS_PER_DIGIT]) : 4'hF;
    end

endmodule

// File: rtl/qr_decoder.sv
module qr_decoder
    import qr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0] rails_i,
    output logic [W-1:0]   word_o,
    output logic           err_o,
    output logic           all_valid_o,
    output logic           all_clear_o
);
    localparam int DIGITS = W / BITS_PER_DIGIT;

    logic [DIGITS-1:0] dig_valid;
    logic [DIGITS-1:0] dig_err;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [3:0] t;
        assign t            = ~rails_i[RAILS_PER_DIGIT*g +: RAILS_PER_DIGIT];
        assign dig_valid[g] = |t;
        assign dig_err[g]   = (t & (t - 4'd1)) != 4'd0;
        assign word_o[BITS_PER_DIGIT*g +: BITS_PER_DIGIT] = digit_value(t);
    end

    assign err_o       = |dig_err;
    assign all_valid_o = &dig_valid;
    assign all_clear_o = ~|dig_valid;

endmodule

// File: rtl/qr_rail_swap.sv
module qr_rail_swap
    import qr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0] rails_i,
    output logic [2*W-1:0] rails_o
);
    localparam int DIGITS = W / BITS_PER_DIGIT;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        localparam int B = RAILS_PER_DIGIT * g;
        assign rails_o[B+3] = rails_i[B+0];
        assign rails_o[B+2] = rails_i[B+1];
        assign rails_o[B+1] = rails_i[B+2];
        assign rails_o[B+0] = rails_i[B+3];
    end

endmodule

// File: rtl/qr_done_fsm.sv
module qr_done_fsm
    import qr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic all_valid_i,
    input  logic all_clear_i,
    output logic done_o
);
    det_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_EMPTY: if (all_valid_i) state_d = DET_FULL;   // FILL
            DET_FULL:  if (all_clear_i) state_d = DET_EMPTY;  // DRAIN
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DET_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        done_o = (state_q == DET_FULL);
    end

endmodule

// File: rtl/quad_rail_codec.sv
module quad_rail_codec #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enc_valid_i,
    input  logic [W-1:0]   enc_word_i,
    output logic [2*W-1:0] enc_rails_o,
    input  logic [2*W-1:0] dec_rails_i,
    output logic [W-1:0]   dec_word_o,
    output logic           dec_err_o,
    output logic [2*W-1:0] inv_rails_o,
    output logic           all_valid_o,
    output logic           all_clear_o,
    output logic           done_o
);

    qr_encoder #(.W(W)) u_enc (
        .valid_i (enc_valid_i),
        .word_i  (enc_word_i),
        .rails_o (enc_rails_o)
    );

    qr_decoder #(.W(W)) u_dec (
        .rails_i     (dec_rails_i),
        .word_o      (dec_word_o),
        .err_o       (dec_err_o),
        .all_valid_o (all_valid_o),
        .all_clear_o (all_clear_o)
    );

    qr_rail_swap #(.W(W)) u_swap (
        .rails_i (dec_rails_i),
        .rails_o (inv_rails_o)
    );

    qr_done_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .all_valid_i (all_valid_o),
        .all_clear_i (all_clear_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/qr_checker.sv
module qr_checker #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enc_valid_i,
    input logic [2*W-1:0] enc_rails_o,
    input logic [2*W-1:0] dec_rails_i,
    input logic [2*W-1:0] inv_rails_o,
    input logic           all_valid_o,
    input logic           all_clear_o,
    input logic           done_o
);
    localparam int DIGITS = W / 2;

    a_r1_enc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |-> (&enc_rails_o));

    a_r2_enc_one_low: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |-> ($countones(~enc_rails_o) == DIGITS));

    a_r5_swap_keeps_lows: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(inv_rails_o) == $countones(dec_rails_i));

    a_r7_fill_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(all_valid_o));

    a_r8_drain_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> $past(all_clear_o));

    a_r9_mixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_valid_o && !all_clear_o) |=> $stable(done_o));

    a_r10_reset_empty: assert property (@(posedge clk)
        !rst_n |-> !done_o);

endmodule

bind quad_rail_codec qr_checker #(.W(W)) u_qr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_valid_i (enc_valid_i),
    .enc_rails_o (enc_rails_o),
    .dec_rails_i (dec_rails_i),
    .inv_rails_o (inv_rails_o),
    .all_valid_o (all_valid_o),
    .all_clear_o (all_clear_o),
    .done_o      (done_o)
);

// File: tb/test_quad_rail_codec.sv
`timescale 1ns/1ps
module test_quad_rail_codec;
    localparam int W = 32;
    localparam int D = W / 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           enc_valid_i;
    logic [W-1:0]   enc_word_i;
    logic [2*W-1:0] enc_rails_o;
    logic [2*W-1:0] dec_rails_i;
    logic [W-1:0]   dec_word_o;
    logic           dec_err_o;
    logic [2*W-1:0] inv_rails_o;
    logic           all_valid_o;
    logic           all_clear_o;
    logic           done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    quad_rail_codec #(.W(W)) i_quad_rail_codec (.*);

    localparam logic [W-1:0] VEC [0:5] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h1B1B_E4E4,
        32'hDEAD_BEEF, 32'h5555_AAAA, 32'h0123_4567
    };

    function automatic logic [2*W-1:0] exp_enc(input logic [W-1:0] w);
        logic [2*W-1:0] r = '1;
        for (int d = 0; d < D; d++) r[4*d + int'(w[2*d +: 2])] = 1'b0;
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic round_trip(input logic [W-1:0] w);
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_word_i  = w;
        #1;
        check(enc_rails_o == exp_enc(w), "R2 encode", enc_rails_o, exp_enc(w));
        dec_rails_i = enc_rails_o;
        #1;
        check(dec_word_o == w, "R3 decode", 64'(dec_word_o), 64'(w));
        check(!dec_err_o, "R4 no error", 64'(dec_err_o), 64'd0);
        check(all_valid_o && !all_clear_o, "R6 valid", 64'({all_valid_o, all_clear_o}), 64'b10);
        check(inv_rails_o == exp_enc(~w), "R5 swap", inv_rails_o, exp_enc(~w));
        dec_rails_i = inv_rails_o;
        #1;
        check(dec_word_o == ~w, "R5 not", 64'(dec_word_o), 64'(~w));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] tgt;
        logic [2*W-1:0] bad;
        rst_n       = 1'b0;
        enc_valid_i = 1'b0;
        enc_word_i  = 32'hA5A5_A5A5;
        dec_rails_i = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!done_o, "R10 reset", 64'(done_o), 64'd0);
        check(&enc_rails_o, "R1 idle clear", enc_rails_o, '1);
        check(all_clear_o && !all_valid_o, "R6 clear", 64'({all_valid_o, all_clear_o}), 64'b01);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < 6; i++) round_trip(VEC[i]);
        for (int i = 0; i < 16; i++) round_trip($urandom);

        // R1 with a nonzero word
        @(negedge clk);
        enc_valid_i = 1'b0;
        enc_word_i  = 32'h1234_5678;
        #1;
        check(&enc_rails_o, "R1 idle ignores word", enc_rails_o, '1);

        // R4: digit 3 with rails 1 and 0 both low
        bad = exp_enc(32'hFFFF_FFFF);
        bad[15:12] = 4'b1100;
        dec_rails_i = bad;
        #1;
        check(dec_err_o, "R4 error", 64'(dec_err_o), 64'd1);
        check(dec_word_o == 32'hFFFF_FF3F, "R3 malformed digit", 64'(dec_word_o), 64'hFFFF_FF3F);

        // hysteresis: start clear
        dec_rails_i = '1;
        @(negedge clk);
        check(!done_o, "R8 clear start", 64'(done_o), 64'd0);
        tgt = exp_enc(32'h1234_5678);
        for (int k = 0; k < D; k++) begin
            dec_rails_i[4*k +: 4] = tgt[4*k +: 4];
            @(negedge clk);
            if (k < D - 1) check(!done_o, "R9 partial set", 64'(done_o), 64'd0);
            else           check(done_o, "R7 fill", 64'(done_o), 64'd1);
        end
        for (int k = 0; k < D; k++) begin
            dec_rails_i[4*k +: 4] = 4'hF;
            @(negedge clk);
            if (k < D - 1) check(done_o, "R9 partial clear", 64'(done_o), 64'd1);
            else           check(!done_o, "R8 drain", 64'(done_o), 64'd0);
        end
        check(dec_word_o == '0, "R3 clear decodes zero", 64'(dec_word_o), 64'd0);

        // mixed again after drain keeps EMPTY
        dec_rails_i[3:0] = 4'b1110;
        @(negedge clk);
        check(!done_o, "R9 mixed from empty", 64'(done_o), 64'd0);

        // reset while FULL
        dec_rails_i = tgt;
        @(negedge clk);
        check(done_o, "R7 refill", 64'(done_o), 64'd1);
        rst_n = 1'b0;
        #1;
        check(!done_o, "R10 reset from full", 64'(done_o), 64'd0);
        @(negedge clk);
        dec_rails_i = '1;
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule